// File: doc/BRIEF.md
# Video Timing Reference and Line Number Inserter

This block sits in a high-definition video transmit path. Every pixel clock it receives one 20-bit word that holds a 10-bit luma sample in the upper half and a 10-bit chroma sample in the lower half. The same words leave the block four clocks later. On the way through, the block rewrites the four-word timing references that mark the start and end of active video, and it also rewrites the two line-number words that follow each end-of-active-video reference. These changes are made identically in both channels.

The horizontal, vertical and field flags that drive the insertion come from one of two sources. The first is the external flag inputs. The second is a search of one selected channel for timing references already embedded in the stream; in that case the block regenerates those references with correct protection bits in both channels. An 11-bit line counter is set to 1 by a falling edge on the line reset input, once per frame. It then advances once per line, after the line-number slot of each end-of-active-video reference.

Top module: `lineTrsInsert`

## Requirements
- R1: With no reference or line-number slot active, each channel of `dataOut` equals the matching channel of `dataIn` exactly four clocks earlier.
- R2: In external mode (`detSel` low), a rising `hIn` marks word n as the first of an end-of-active-video reference. In both channels, words n..n+3 leave as 3FF, 000, 000 and then the status word.
- R3: In external mode, a falling `hIn` marks word n as the first of a start-of-active-video reference. It gets the same four words, with the status word's H bit at 0, and no line-number words follow it.
- R4: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}, written from bit 9 down to bit 0. F, V and H are the flags valid at the first word of the reference.
- R5: After an end-of-active-video reference, words n+4 and n+5 carry line number L in both channels. The first is {~L[6], L[6:0], 00} and the second is {1, 000, L[10:7], 00}.
- R6: A high-to-low transition on `lineRstIn` sets the line counter to 1. The next end-of-active-video reference then carries line 1.
- R7: The counter advances by one after the line-number slot of each end-of-active-video reference, unless a line reset edge occurs in that cycle.
- R8: With `trsInsEn` low, the four reference words pass through unchanged. Line numbers are still inserted.
- R9: With `lnInsEn` low, the two line-number words pass through unchanged.
- R10: With `detSel` high, the flags come from embedded references (3FF, 000, 000, then a word with bit 9 set, whose bits 8, 7 and 6 give F, V and H), and `hIn` is ignored. A detected reference is rewritten in both channels on the same four words.
- R11: In detect mode, `chanSel` high searches luma (bits 19:10) and low searches chroma (bits 9:0). References in the other channel are not acted on.
- R12: With `detSel` high, line-number words are never inserted, whatever `lnInsEn` is.
- R13: While `rstN` is low, `dataOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 20 | Luma in 19:10, chroma in 9:0 |
| hIn | input | 1 | External horizontal blanking flag |
| vIn | input | 1 | External vertical blanking flag |
| fIn | input | 1 | External field flag (low for progressive) |
| detSel | input | 1 | High: flags from embedded references; low: external flags |
| chanSel | input | 1 | Detect channel: high luma, low chroma |
| trsInsEn | input | 1 | Enables rewriting of reference words |
| lnInsEn | input | 1 | Enables line-number insertion |
| lineRstIn | input | 1 | Falling edge sets the line counter to 1 |
| dataOut | output | 20 | Formatted luma and chroma words |

## Verification
The bench drives 64-word lines with distinct filler values in each channel, so a rewritten word cannot be mistaken for a passed-through one. External lines toggle H with different V and F values, which separates start references from end references and tests each status-word bit. Line numbers 1, 2 and 3 are checked across successive streams, and a mid-stream line reset is checked as well. Detect-mode streams embed a reference in only one channel with deliberately wrong protection bits while `hIn` toggles. This shows that the flags follow the searched channel only, that the other channel is overwritten, and that no line numbers appear.

// File: rtl/lineTrsPkg.sv
package lineTrsPkg;
  localparam int WORD_W = 10;
  localparam int LN_W = 11;
  localparam int BUS_W = 2 * WORD_W;
  localparam int FLAG_F = WORD_W - 2;
  localparam int FLAG_V = WORD_W - 3;
  localparam int FLAG_H = WORD_W - 4;

  typedef enum logic [2:0] {
    SEL_PASS, SEL_ONES, SEL_ZERO, SEL_XYZ, SEL_LN0, SEL_LN1
  } wordSelE;

  typedef struct packed {
    wordSelE sel;
    logic f;
    logic v;
    logic h;
    logic [LN_W-1:0] lineNum;
  } strobeT;
endpackage

// File: rtl/lineTrsCtrl.sv
module lineTrsCtrl
  import lineTrsPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] inWord,
  input  logic             hIn,
  input  logic             vIn,
  input  logic             fIn,
  input  logic             detSel,
  input  logic             chanSel,
  input  logic             trsInsEn,
  input  logic             lnInsEn,
  input  logic             lineRstIn,
  output strobeT           strb
);
  localparam int DLY = 3;

  logic [DLY-1:0] hP, vP, fP, onesP, zeroP;
  logic detH, detV, detF, hLast;
  logic [2:0] seqPos;
  logic seqBusy, seqEav, fL, vL, hL;
  logic [LN_W-1:0] lineCnt;
  logic lineRstPrev;

  logic [WORD_W-1:0] srchWord;
  logic isOnes, isZero, match, effH, effV, effF, edgeNow;
  logic active, curEav, lineEdge;
  logic [2:0] curPos, lastPos;

  always_comb begin
    srchWord = chanSel ? inWord[BUS_W-1:WORD_W] : inWord[WORD_W-1:0];
    isOnes   = &srchWord;
    isZero   = ~|srchWord;
    // reference complete when the status word arrives at the input
    match    = onesP[DLY-1] & zeroP[DLY-2] & zeroP[DLY-3] & srchWord[WORD_W-1];
    if (detSel) begin
      effH = match ? srchWord[FLAG_H] : detH;
      effV = match ? srchWord[FLAG_V] : detV;
      effF = match ? srchWord[FLAG_F] : detF;
    end else begin
      effH = hP[DLY-1];
      effV = vP[DLY-1];
      effF = fP[DLY-1];
    end
    edgeNow = effH != hLast;
    active  = edgeNow | seqBusy;
    curPos  = edgeNow ? 3'd0 : seqPos;
    curEav  = edgeNow ? effH : seqEav;
    lastPos = curEav ? 3'd5 : 3'd3;
    lineEdge = lineRstPrev & ~lineRstIn;

    strb.sel = SEL_PASS;
    if (active) begin
      case (curPos)
        3'd0:    strb.sel = trsInsEn ? SEL_ONES : SEL_PASS;
        3'd1,
        3'd2:    strb.sel = trsInsEn ? SEL_ZERO : SEL_PASS;
        3'd3:    strb.sel = trsInsEn ? SEL_XYZ : SEL_PASS;
        3'd4:    strb.sel = (curEav && lnInsEn && !detSel) ? SEL_LN0 : SEL_PASS;
        3'd5:    strb.sel = (curEav && lnInsEn && !detSel) ? SEL_LN1 : SEL_PASS;
        default: strb.sel = SEL_PASS;
      endcase
    end
    strb.f = edgeNow ? effF : fL;
    strb.v = edgeNow ? effV : vL;
    strb.h = edgeNow ? effH : hL;
    strb.lineNum = lineCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hP <= '0; vP <= '0; fP <= '0; onesP <= '0; zeroP <= '0;
      detH <= 1'b0; detV <= 1'b0; detF <= 1'b0; hLast <= 1'b0;
      seqPos <= '0; seqBusy <= 1'b0; seqEav <= 1'b0;
      fL <= 1'b0; vL <= 1'b0; hL <= 1'b0;
      lineCnt <= LN_W'(1); lineRstPrev <= 1'b1;
    end else begin
      hP    <= {hP[DLY-2:0], hIn};
      vP    <= {vP[DLY-2:0], vIn};
      fP    <= {fP[DLY-2:0], fIn};
      onesP <= {onesP[DLY-2:0], isOnes};
      zeroP <= {zeroP[DLY-2:0], isZero};
      if (detSel && match) begin
        detH <= srchWord[FLAG_H];
        detV <= srchWord[FLAG_V];
        detF <= srchWord[FLAG_F];
      end
      hLast <= effH;
      if (edgeNow) begin
        seqEav <= effH;
        fL <= effF; vL <= effV; hL <= effH;
      end
      if (active && curPos != lastPos) begin
        seqPos  <= 3'(curPos + 3'd1);
        seqBusy <= 1'b1;
      end else begin
        seqBusy <= 1'b0;
      end
      lineRstPrev <= lineRstIn;
      if (lineEdge) lineCnt <= LN_W'(1);
      else if (active && curEav && curPos == 3'd5) lineCnt <= LN_W'(lineCnt + 1'b1);
    end
  end
endmodule

// File: rtl/lineTrsPath.sv
module lineTrsPath
  import lineTrsPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] inWord,
  input  strobeT           strb,
  output logic [BUS_W-1:0] dataOut
);
  logic [BUS_W-1:0] p0, p1, p2;
  logic [WORD_W-1:0] xyzW, ln0W, ln1W;
  logic [1:0][WORD_W-1:0] nxtW;

  always_comb begin
    xyzW = {1'b1, strb.f, strb.v, strb.h, strb.v ^ strb.h, strb.f ^ strb.h,
            strb.f ^ strb.v, strb.f ^ strb.v ^ strb.h, 2'b00};
    ln0W = {~strb.lineNum[6], strb.lineNum[6:0], 2'b00};
    ln1W = {1'b1, 3'b000, strb.lineNum[10:7], 2'b00};
  end

  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    logic [WORD_W-1:0] src;
    assign src = p2[ch*WORD_W +: WORD_W];
    always_comb begin
      case (strb.sel)
        SEL_ONES: nxtW[ch] = '1;
        SEL_ZERO: nxtW[ch] = '0;
        SEL_XYZ:  nxtW[ch] = xyzW;
        SEL_LN0:  nxtW[ch] = ln0W;
        SEL_LN1:  nxtW[ch] = ln1W;
        default:  nxtW[ch] = src;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0 <= '0; p1 <= '0; p2 <= '0; dataOut <= '0;
    end else begin
      p0 <= inWord;
      p1 <= p0;
      p2 <= p1;
      dataOut <= nxtW;
    end
  end
endmodule

// File: rtl/lineTrsInsert.sv
module lineTrsInsert
  import lineTrsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] dataIn,
  input  logic        hIn,
  input  logic        vIn,
  input  logic        fIn,
  input  logic        detSel,
  input  logic        chanSel,
  input  logic        trsInsEn,
  input  logic        lnInsEn,
  input  logic        lineRstIn,
  output logic [19:0] dataOut
);
  strobeT strb;

  lineTrsCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .inWord(dataIn), .hIn(hIn), .vIn(vIn), .fIn(fIn),
    .detSel(detSel), .chanSel(chanSel), .trsInsEn(trsInsEn), .lnInsEn(lnInsEn),
    .lineRstIn(lineRstIn), .strb(strb)
  );

  lineTrsPath i_path (
    .clk(clk), .rstN(rstN), .inWord(dataIn), .strb(strb), .dataOut(dataOut)
  );
endmodule

// File: rtl/lineTrsInsertChk.sv
module lineTrsInsertChk
  import lineTrsPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             lineRstIn,
  input logic             detSel,
  input wordSelE          sel,
  input logic [LN_W-1:0]  lineNum,
  input logic [BUS_W-1:0] dataOut
);
  AST_HDR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_ONES) |=> (dataOut == {BUS_W{1'b1}})); // R2

  AST_XYZ_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_XYZ) |=> (dataOut[BUS_W-1] && dataOut[WORD_W-1] &&
                          dataOut[WORD_W+1:WORD_W] == 2'b00 && dataOut[1:0] == 2'b00)); // R4

  AST_LN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineRstIn) |=> (lineNum == LN_W'(1))); // R6

  AST_LN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineNum) |-> (lineNum == LN_W'(1) || lineNum == LN_W'($past(lineNum) + 1'b1))); // R7

  AST_NO_LN_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    detSel |-> (sel != SEL_LN0 && sel != SEL_LN1)); // R12
endmodule

bind lineTrsInsert lineTrsInsertChk i_chk (
  .clk(clk), .rstN(rstN), .lineRstIn(lineRstIn), .detSel(detSel),
  .sel(strb.sel), .lineNum(strb.lineNum), .dataOut(dataOut)
);

// File: tb/test_lineTrsInsert.sv
`timescale 1ns/1ps
module test_lineTrsInsert;
  localparam int N = 64;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [19:0] dataIn = '0;
  logic hIn = 1'b0, vIn = 1'b0, fIn = 1'b0;
  logic detSel = 1'b0, chanSel = 1'b1, trsInsEn = 1'b1, lnInsEn = 1'b1;
  logic lineRstIn = 1'b1;
  logic [19:0] dataOut;

  int checks = 0;
  int failures = 0;

  logic [9:0] yA [N];
  logic [9:0] cA [N];
  logic hA [N], vA [N], fA [N], rA [N];
  logic [9:0] oY [N];
  logic [9:0] oC [N];

  always #2.5 clk = ~clk;

  lineTrsInsert i_lineTrsInsert (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .hIn(hIn), .vIn(vIn), .fIn(fIn),
    .detSel(detSel), .chanSel(chanSel), .trsInsEn(trsInsEn), .lnInsEn(lnInsEn),
    .lineRstIn(lineRstIn), .dataOut(dataOut)
  );

  task automatic chk(input string req, input string what, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic chkWord(input string req, input int idx, input logic [9:0] ey, input logic [9:0] ec);
    chk(req, $sformatf("luma word %0d", idx), {10'h0, oY[idx]}, {10'h0, ey});
    chk(req, $sformatf("chroma word %0d", idx), {10'h0, oC[idx]}, {10'h0, ec});
  endtask

  task automatic fill(input logic [9:0] y, input logic [9:0] c);
    for (int i = 0; i < N; i++) begin
      yA[i] = y; cA[i] = c; hA[i] = 1'b0; vA[i] = 1'b0; fA[i] = 1'b0; rA[i] = lineRstIn;
    end
  endtask

  task automatic setH(input int a, input int b);
    for (int i = a; i <= b; i++) hA[i] = 1'b1;
  endtask

  task automatic runStream();
    for (int i = 0; i < N + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        oY[i-LAT] = dataOut[19:10];
        oC[i-LAT] = dataOut[9:0];
      end
      if (i < N) begin
        dataIn = {yA[i], cA[i]}; hIn = hA[i]; vIn = vA[i]; fIn = fA[i]; lineRstIn = rA[i];
      end else begin
        dataIn = {yA[N-1], cA[N-1]}; hIn = hA[N-1]; vIn = vA[N-1]; fIn = fA[N-1]; lineRstIn = rA[N-1];
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R13", "output in reset", dataOut, 20'h0);
  endtask

  task automatic testPass();
    fill(10'h040, 10'h155);
    for (int i = 0; i < N; i++) begin
      yA[i] = 10'(10'h040 + i * 7);
      cA[i] = 10'(10'h300 - i * 5);
    end
    runStream();
    for (int i = 0; i < N; i += 9) chkWord("R1", i, yA[i], cA[i]);
  endtask

  task automatic testExtEav();
    fill(10'h040, 10'h155);
    for (int i = 0; i < N; i++) begin rA[i] = 1'b0; vA[i] = 1'b1; end
    setH(10, 29); setH(50, 59);
    runStream();
    chkWord("R2", 10, 10'h3FF, 10'h3FF);
    chkWord("R2", 11, 10'h000, 10'h000);
    chkWord("R2", 12, 10'h000, 10'h000);
    chkWord("R4", 13, 10'h2D8, 10'h2D8);
    chkWord("R6", 14, 10'h204, 10'h204);
    chkWord("R5", 15, 10'h200, 10'h200);
    chkWord("R1", 16, 10'h040, 10'h155);
    chkWord("R3", 30, 10'h3FF, 10'h3FF);
    chkWord("R3", 33, 10'h2AC, 10'h2AC);
    chkWord("R3", 34, 10'h040, 10'h155);
    chkWord("R7", 54, 10'h208, 10'h208);
  endtask

  task automatic testTrsOff();
    trsInsEn = 1'b0;
    fill(10'h040, 10'h155);
    setH(10, 29); setH(50, 59);
    runStream();
    chkWord("R8", 10, 10'h040, 10'h155);
    chkWord("R8", 13, 10'h040, 10'h155);
    chkWord("R8", 14, 10'h20C, 10'h20C);
    trsInsEn = 1'b1;
  endtask

  task automatic testLnOff();
    lnInsEn = 1'b0;
    fill(10'h040, 10'h155);
    for (int i = 0; i < N; i++) fA[i] = 1'b1;
    setH(10, 29); setH(50, 59);
    runStream();
    chkWord("R4", 13, 10'h368, 10'h368);
    chkWord("R9", 14, 10'h040, 10'h155);
    chkWord("R9", 15, 10'h040, 10'h155);
    lnInsEn = 1'b1;
    for (int i = 0; i < N; i++) fA[i] = 1'b0;
  endtask

  task automatic testDetect();
    detSel = 1'b1; chanSel = 1'b1;
    fill(10'h040, 10'h155);
    setH(3, 5);
    yA[20] = 10'h3FF; yA[21] = 10'h000; yA[22] = 10'h000; yA[23] = 10'h340;
    runStream();
    chkWord("R10", 3, 10'h040, 10'h155);
    chkWord("R10", 20, 10'h3FF, 10'h3FF);
    chkWord("R10", 21, 10'h000, 10'h000);
    chkWord("R10", 23, 10'h368, 10'h368);
    chkWord("R12", 24, 10'h040, 10'h155);
    chkWord("R12", 25, 10'h040, 10'h155);
  endtask

  task automatic testChanSel();
    detSel = 1'b1; chanSel = 1'b0;
    fill(10'h040, 10'h155);
    yA[20] = 10'h3FF; yA[21] = 10'h000; yA[22] = 10'h000; yA[23] = 10'h23C;
    runStream();
    chkWord("R11", 20, 10'h3FF, 10'h155);
    chkWord("R11", 21, 10'h000, 10'h155);
    chkWord("R11", 23, 10'h23C, 10'h155);
    detSel = 1'b0; chanSel = 1'b1;
  endtask

  task automatic testLineReset();
    fill(10'h040, 10'h155);
    for (int i = 0; i < N; i++) rA[i] = (i < 20) ? 1'b1 : 1'b0;
    setH(10, 29); setH(50, 59);
    runStream();
    chkWord("R6", 54, 10'h204, 10'h204);
    chkWord("R6", 55, 10'h200, 10'h200);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testPass();
    testExtEav();
    testTrsOff();
    testLnOff();
    testDetect();
    testChanSel();
    testLineReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule